// File: doc/BRIEF.md
# CCD Integration and Command Controller

This block is the top-level sequencing controller for a CCD camera. It decides when the detector is flushed, when it integrates and when it is read out. It issues single-cycle requests to an external clock sequencer and waits for that sequencer's completion inputs. Out of reset it runs an autonomous cycle of flush, timed integration and readout, with a nominal ten-second period. It stays in that cycle until the instrument controller sends a command to leave it. From then on, the controller's own readout commands set the integration time.

Commands arrive as an opcode with a valid strobe. Configuration writes land in a shadow register at any time. They reach the active configuration only when an update command is given. If the update arrives while a readout is running, the copy is held back until the sequencer reports that readout is complete. One configuration bit selects whether a new image starts with or without a flush. A master-reset command restores every default and returns the block to autonomous operation.

States: `ST_BOOT` (one cycle after reset or master reset), `ST_FLUSH` (flush requested, waiting for flush done), `ST_INTEG` (integrating, timed when autonomous), `ST_READ` (readout requested, waiting for readout done) and `ST_EOF` (one-cycle frame close). The transitions are:
- BOOT to FLUSH or INTEG, chosen by the skip-flush bit.
- FLUSH to INTEG when flush done arrives.
- INTEG to READ on timer expiry (autonomous) or on a readout command (commanded).
- INTEG to FLUSH on a flush command (commanded).
- READ to EOF when readout done arrives.
- EOF to FLUSH or INTEG, chosen by the skip-flush bit.
- Any state to BOOT on master reset.

Top module: `intcmd_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after its release, `flush_req`, `readout_start`, `eof` and `busy` are 0 and `active_cfg` equals `CFG_DEFAULT`. With the default skip-flush bit at 0, `flush_req` pulses on the cycle after the first clock edge following release.
- R2: In autonomous mode, `readout_start` pulses exactly `PRESCALE*PERIOD_TICKS` clock edges after the edge that samples `flush_done` high, with no command needed.
- R3: `busy` is 1 from the cycle in which `readout_start` pulses until `readout_done` is sampled. `eof` pulses for one cycle on the cycle after that edge, and `busy` is 0 in that cycle.
- R4: After the `eof` cycle, `flush_req` pulses on the next cycle if bit `NOFLUSH_BIT` (bit 0) of `active_cfg` is 0. If the bit is 1, no flush is requested and integration starts at once. In autonomous mode the next `readout_start` then comes `PRESCALE*PERIOD_TICKS+1` edges after the `eof` cycle.
- R5: Opcode 3'd1 (stop autonomous) ends the timed cycle. No `readout_start` occurs afterwards without a command.
- R6: Once autonomous mode is stopped and the block is integrating, opcode 3'd3 (readout) makes `readout_start` pulse on the cycle after the command is sampled. Opcode 3'd2 (flush) does the same for `flush_req`.
- R7: While `busy` is 1, opcodes 3'd1, 3'd2 and 3'd3 are ignored. No request pulses, `busy` stays 1, and the autonomous cycle continues if it was running.
- R8: A configuration write (`cfg_wr`) changes only the shadow register. Opcode 3'd4 (update), given while not busy, copies the shadow to `active_cfg` on the edge that samples it.
- R9: Opcode 3'd4 given while busy leaves `active_cfg` unchanged until `readout_done`. `active_cfg` then takes the shadow value, visible in the `eof` cycle.
- R10: Opcode 3'd7 (master reset) is accepted in any state, including during readout. On the next cycle `busy` is 0 and `active_cfg` equals `CFG_DEFAULT`. Any deferred update is discarded, and autonomous operation resumes with a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| cfg_wr | input | 1 | Write strobe for the shadow configuration |
| cfg_wdata | input | CFG_W | Shadow configuration write value |
| flush_done | input | 1 | Sequencer has finished a flush |
| readout_done | input | 1 | Sequencer has finished a readout |
| flush_req | output | 1 | One-cycle request to flush the CCD |
| readout_start | output | 1 | One-cycle request to read out the CCD |
| busy | output | 1 | Readout in progress |
| eof | output | 1 | One-cycle end-of-frame pulse |
| active_cfg | output | CFG_W | Configuration in force |

## Verification
A wrong state register appears within one cycle: it shows as a request pulse with no cause, a missing `eof`, or `busy` failing to track the readout handshake. Timer faults appear as a `readout_start` that arrives a cycle early or late against the exact integration count. A fault in stop or busy gating appears as a readout pulse inside a long quiet window. Shadow or pending-update faults appear at `active_cfg` either on the update edge or in the `eof` cycle.

// File: rtl/intcmd_pkg.sv
package intcmd_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_STOPAUT = 3'd1,
        OP_FLUSH   = 3'd2,
        OP_READOUT = 3'd3,
        OP_UPDATE  = 3'd4,
        OP_MRESET  = 3'd7
    } cmd_op_e;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_FLUSH,
        ST_INTEG,
        ST_READ,
        ST_EOF
    } ctrl_state_e;

    typedef struct packed {
        logic mrst;
        logic stop_auto;
        logic flush;
        logic readout;
        logic upd_now;
        logic upd_defer;
    } cmd_act_t;

endpackage

// File: rtl/intcmd_decode.sv
module intcmd_decode
    import intcmd_pkg::*;
(
    input  logic     cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic     in_read,
    input  logic     man_integ,
    output cmd_act_t act
);

    logic is_stop, is_flush, is_read, is_upd, is_mrst;

    always_comb begin
        is_stop  = cmd_valid && (cmd_op == OP_STOPAUT);
        is_flush = cmd_valid && (cmd_op == OP_FLUSH);
        is_read  = cmd_valid && (cmd_op == OP_READOUT);
        is_upd   = cmd_valid && (cmd_op == OP_UPDATE);
        is_mrst  = cmd_valid && (cmd_op == OP_MRESET);
    end

    // Master reset always passes; an update during readout is deferred,
    // every other command is dropped while the readout runs.
    always_comb begin
        act.mrst      = is_mrst;
        act.stop_auto = is_stop  && !in_read;
        act.flush     = is_flush && man_integ;
        act.readout   = is_read  && man_integ;
        act.upd_now   = is_upd   && !in_read;
        act.upd_defer = is_upd   &&  in_read;
    end

endmodule

// File: rtl/intcmd_timer.sv
module intcmd_timer #(
    parameter int PRESCALE     = 50_000_000,
    parameter int PERIOD_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic run,
    output logic expire
);

    localparam int PW = $clog2(PRESCALE > 1 ? PRESCALE : 2);
    localparam int TW = $clog2(PERIOD_TICKS > 1 ? PERIOD_TICKS : 2);
    localparam logic [PW-1:0] PRE_TOP  = PW'(PRESCALE - 1);
    localparam logic [TW-1:0] TICK_TOP = TW'(PERIOD_TICKS - 1);

    logic [PW-1:0] presc_q;
    logic [TW-1:0] ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= PRE_TOP;
            ticks_q <= TICK_TOP;
        end else if (clr || load) begin
            presc_q <= PRE_TOP;
            ticks_q <= TICK_TOP;
        end else if (run) begin
            if (presc_q == '0) begin
                presc_q <= PRE_TOP;
                if (ticks_q != '0)
                    ticks_q <= ticks_q - 1'b1;
            end else begin
                presc_q <= presc_q - 1'b1;
            end
        end
    end

    always_comb expire = run && (presc_q == '0) && (ticks_q == '0);

endmodule

// File: rtl/intcmd_cfg.sv
module intcmd_cfg #(
    parameter int              CFG_W       = 16,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             upd_now,
    input  logic             upd_defer,
    input  logic             read_closing,
    output logic [CFG_W-1:0] active
);

    logic [CFG_W-1:0] shadow_q;
    logic [CFG_W-1:0] active_q;
    logic             pend_q;
    logic             apply_deferred;

    always_comb apply_deferred = read_closing && (pend_q || upd_defer);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= CFG_DEFAULT;
        end else if (mrst) begin
            shadow_q <= CFG_DEFAULT;
        end else if (wr) begin
            shadow_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= CFG_DEFAULT;
            pend_q   <= 1'b0;
        end else if (mrst) begin
            active_q <= CFG_DEFAULT;
            pend_q   <= 1'b0;
        end else if (upd_now || apply_deferred) begin
            active_q <= shadow_q;
            pend_q   <= 1'b0;
        end else if (upd_defer) begin
            pend_q   <= 1'b1;
        end
    end

    always_comb active = active_q;

endmodule

// File: rtl/intcmd_ctrl.sv
module intcmd_ctrl
    import intcmd_pkg::*;
#(
    parameter int               CFG_W        = 16,
    parameter logic [CFG_W-1:0] CFG_DEFAULT  = '0,
    parameter int               NOFLUSH_BIT  = 0,
    parameter int               PRESCALE     = 50_000_000,
    parameter int               PERIOD_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             flush_done,
    input  logic             readout_done,
    output logic             flush_req,
    output logic             readout_start,
    output logic             busy,
    output logic             eof,
    output logic [CFG_W-1:0] active_cfg
);

    ctrl_state_e state_q, nxt;
    logic        cont_en_q;
    cmd_act_t    act;
    logic        expire;
    logic        in_read, man_integ, noflush;
    logic        tmr_load, tmr_run;
    logic        flush_req_q, readout_start_q, busy_q, eof_q;

    always_comb begin
        in_read   = (state_q == ST_READ);
        man_integ = (state_q == ST_INTEG) && !cont_en_q;
        noflush   = active_cfg[NOFLUSH_BIT];
    end

    intcmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .in_read   (in_read),
        .man_integ (man_integ),
        .act       (act)
    );

    intcmd_cfg #(
        .CFG_W       (CFG_W),
        .CFG_DEFAULT (CFG_DEFAULT)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mrst         (act.mrst),
        .wr           (cfg_wr),
        .wdata        (cfg_wdata),
        .upd_now      (act.upd_now),
        .upd_defer    (act.upd_defer),
        .read_closing (in_read && readout_done),
        .active       (active_cfg)
    );

    always_comb begin
        tmr_load = (nxt == ST_INTEG) && (state_q != ST_INTEG);
        tmr_run  = (state_q == ST_INTEG) && cont_en_q;
    end

    intcmd_timer #(
        .PRESCALE     (PRESCALE),
        .PERIOD_TICKS (PERIOD_TICKS)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (act.mrst),
        .load   (tmr_load),
        .run    (tmr_run),
        .expire (expire)
    );

    // Autonomous-mode flag: set by any reset, cleared by the stop command.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cont_en_q <= 1'b1;
        else if (act.mrst)
            cont_en_q <= 1'b1;
        else if (act.stop_auto)
            cont_en_q <= 1'b0;
    end

    // Next-state selection.
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_BOOT:  nxt = noflush ? ST_INTEG : ST_FLUSH;
            ST_FLUSH: if (flush_done) nxt = ST_INTEG;
            ST_INTEG: begin
                if (cont_en_q && !act.stop_auto && expire)
                    nxt = ST_READ;
                else if (act.readout)
                    nxt = ST_READ;
                else if (act.flush)
                    nxt = ST_FLUSH;
            end
            ST_READ:  if (readout_done) nxt = ST_EOF;
            ST_EOF:   nxt = noflush ? ST_INTEG : ST_FLUSH;
            default:  nxt = ST_BOOT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_BOOT;
        else if (act.mrst)
            state_q <= ST_BOOT;
        else
            state_q <= nxt;
    end

    // Registered outputs, aligned with the state they describe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flush_req_q     <= 1'b0;
            readout_start_q <= 1'b0;
            busy_q          <= 1'b0;
            eof_q           <= 1'b0;
        end else if (act.mrst) begin
            flush_req_q     <= 1'b0;
            readout_start_q <= 1'b0;
            busy_q          <= 1'b0;
            eof_q           <= 1'b0;
        end else begin
            flush_req_q     <= (nxt == ST_FLUSH) && (state_q != ST_FLUSH);
            readout_start_q <= (nxt == ST_READ)  && (state_q != ST_READ);
            busy_q          <= (nxt == ST_READ);
            eof_q           <= (nxt == ST_EOF);
        end
    end

    always_comb begin
        flush_req     = flush_req_q;
        readout_start = readout_start_q;
        busy          = busy_q;
        eof           = eof_q;
    end

endmodule

// File: rtl/intcmd_ctrl_chk.sv
module intcmd_ctrl_chk
    import intcmd_pkg::*;
#(
    parameter int               CFG_W       = 16,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             readout_done,
    input logic             flush_req,
    input logic             readout_start,
    input logic             busy,
    input logic             eof,
    input logic [CFG_W-1:0] active_cfg
);

    logic mrst_cmd, upd_cmd;
    always_comb begin
        mrst_cmd = cmd_valid && (cmd_op == OP_MRESET);
        upd_cmd  = cmd_valid && (cmd_op == OP_UPDATE);
    end

    AST_EOF_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> $past(busy && readout_done)); // R3

    AST_START_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        readout_start |-> busy); // R3

    AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, readout_start, eof})); // R4

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !readout_done && !mrst_cmd) |=> busy); // R7

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !readout_done && !mrst_cmd) |=> $stable(active_cfg)); // R9

    AST_CFG_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_cmd && !mrst_cmd && !(busy && readout_done)) |=> $stable(active_cfg)); // R8

    AST_MRESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        mrst_cmd |=> (!busy && (active_cfg == CFG_DEFAULT))); // R10

endmodule

bind intcmd_ctrl intcmd_ctrl_chk #(
    .CFG_W       (CFG_W),
    .CFG_DEFAULT (CFG_DEFAULT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .readout_done  (readout_done),
    .flush_req     (flush_req),
    .readout_start (readout_start),
    .busy          (busy),
    .eof           (eof),
    .active_cfg    (active_cfg)
);

// File: tb/sim_intcmd_ctrl.sv
module sim_intcmd_ctrl;

    localparam int PRE   = 4;
    localparam int TICKS = 5;
    localparam int NINT  = PRE * TICKS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = 16'h0;
    logic        flush_done = 1'b0;
    logic        readout_done = 1'b0;
    logic        flush_req, readout_start, busy, eof;
    logic [15:0] active_cfg;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    intcmd_ctrl #(
        .CFG_W        (16),
        .CFG_DEFAULT  (16'h0000),
        .NOFLUSH_BIT  (0),
        .PRESCALE     (PRE),
        .PERIOD_TICKS (TICKS)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cfg_wr        (cfg_wr),
        .cfg_wdata     (cfg_wdata),
        .flush_done    (flush_done),
        .readout_done  (readout_done),
        .flush_req     (flush_req),
        .readout_start (readout_start),
        .busy          (busy),
        .eof           (eof),
        .active_cfg    (active_cfg)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] op);
        cmd_valid = 1'b1;
        cmd_op    = op;
        step();
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        step();
        cfg_wr    = 1'b0;
    endtask

    task automatic pulse_fd();
        flush_done = 1'b1;
        step();
        flush_done = 1'b0;
    endtask

    task automatic pulse_rd();
        readout_done = 1'b1;
        step();
        readout_done = 1'b0;
    endtask

    task automatic wait_ro(output int n, output int fl);
        n  = 0;
        fl = 0;
        while (!readout_start && n < 300) begin
            step();
            n++;
            if (flush_req) fl++;
        end
    endtask

    task automatic quiet(input int cyc, output int ro);
        ro = 0;
        for (int i = 0; i < cyc; i++) begin
            step();
            if (readout_start) ro++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 flush_req in reset", flush_req, 0);
        check("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        check("R1 eof after release", eof, 0);
        check("R1 readout_start after release", readout_start, 0);
        check("R1 active_cfg default", active_cfg, 16'h0000);
        step();
        check("R1 first flush_req", flush_req, 1);
    endtask

    task automatic t_autonomous();
        int n, fl;
        pulse_fd();
        wait_ro(n, fl);
        check("R2 integration length", n, NINT);
        check("R3 busy with readout_start", busy, 1);
        repeat (3) step();
        check("R3 busy held", busy, 1);
        check("R3 no eof yet", eof, 0);
        pulse_rd();
        check("R3 eof pulse", eof, 1);
        check("R3 busy dropped", busy, 0);
        step();
        check("R4 flush after eof", flush_req, 1);
        check("R3 eof single cycle", eof, 0);
    endtask

    task automatic t_noflush();
        int n, fl;
        wr_cfg(16'h0001);
        check("R8 write alone no effect", active_cfg, 16'h0000);
        cmd(3'd4);
        check("R8 update applies", active_cfg, 16'h0001);
        pulse_fd();
        wait_ro(n, fl);
        check("R2 second integration", n, NINT);
        pulse_rd();
        check("R3 eof", eof, 1);
        wait_ro(n, fl);
        check("R4 skip-flush integration", n, NINT + 1);
        check("R4 no flush requested", fl, 0);
    endtask

    task automatic t_busy_ignore();
        int n, fl;
        cmd(3'd2);
        check("R7 flush ignored", flush_req, 0);
        cmd(3'd3);
        check("R7 readout ignored", readout_start, 0);
        cmd(3'd1);
        check("R7 busy kept", busy, 1);
        wr_cfg(16'h00A5);
        cmd(3'd4);
        repeat (2) step();
        check("R9 deferred hold", active_cfg, 16'h0001);
        pulse_rd();
        check("R9 applied at eof", active_cfg, 16'h00A5);
        wait_ro(n, fl);
        check("R7 stop ignored, still autonomous", n, NINT + 1);
    endtask

    task automatic t_stop();
        int ro;
        pulse_rd();
        cmd(3'd1);
        quiet(3 * NINT, ro);
        check("R5 no autonomous readout", ro, 0);
    endtask

    task automatic t_manual();
        int ro;
        cmd(3'd3);
        check("R6 readout on command", readout_start, 1);
        check("R6 busy", busy, 1);
        pulse_rd();
        check("R3 manual eof", eof, 1);
        step();
        cmd(3'd2);
        check("R6 flush on command", flush_req, 1);
        pulse_fd();
        quiet(2 * NINT, ro);
        check("R5 still quiet", ro, 0);
        wr_cfg(16'h00A4);
        cmd(3'd4);
        check("R8 update idle", active_cfg, 16'h00A4);
        cmd(3'd3);
        pulse_rd();
        step();
        check("R4 manual flush after eof", flush_req, 1);
        pulse_fd();
    endtask

    task automatic t_mreset();
        int n, fl;
        cmd(3'd3);
        check("R10 busy before reset", busy, 1);
        wr_cfg(16'h0003);
        cmd(3'd4);
        cmd(3'd7);
        check("R10 busy cleared", busy, 0);
        check("R10 cfg default", active_cfg, 16'h0000);
        check("R10 no flush yet", flush_req, 0);
        step();
        check("R10 flush after reset", flush_req, 1);
        pulse_fd();
        wait_ro(n, fl);
        check("R10 autonomous resumes", n, NINT);
        pulse_rd();
        check("R10 deferred update dropped", active_cfg, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_autonomous();
        t_noflush();
        t_busy_ignore();
        t_stop();
        t_manual();
        t_mreset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule